// File: doc/BRIEF.md
# Output Clock Gate and Power-Down Sequencer

This block sits between a set of free-running clock sources and the output pins of a clock generator. Each output is passed through a gate that opens and closes only while its source clock is low. Each output has its own enable bit, and the gates are also controlled by a power sequencer. A global float control turns off the pad drivers of all outputs at once. The PLL, the crystal oscillator and the pad drivers are outside the block. It sees them only as incoming clocks and drives an oscillator enable, a VCO enable and a pad-drive enable.

The power-down request is an asynchronous, active-low pin. After synchronisation, the sequencer closes every gate so that each output stops low at the next falling edge of its own source. It waits until it has seen every gate closed, and only then drops the oscillator and VCO enables. When the pin is released, both enables return at once. A settle window of a parameterised number of sequencer clocks then models the power-up latency limit, and the gates stay closed until it has passed. A new request during that window sends the sequencer straight back to stopping.

Per-output enable bits are captured on rising edges of the free-running PCI clock. Each gate takes up the captured value at the next falling edge of its own source, so enabling or disabling an output never creates a runt pulse.

Top module: `clk_gate_seq`

## Requirements
- R1: While reset is asserted, all outputs are low and the oscillator and VCO enables are high. After reset is released, no output rises during the first SETTLE_CYC-2 sequencer clocks, and every enabled output toggles soon after SETTLE_CYC clocks.
- R2: The power-down pin passes through a two-flop synchroniser on `clk`. After the pin rises, with the sequencer powered down, the VCO enable is still low after the second `clk` rising edge and is high after the third.
- R3: After the power-down pin falls, the gates close on the third `clk` rising edge. The CPU output (index 0, source period 8 ns) is low and no longer rises from one source period after that edge.
- R4: The oscillator and VCO enables fall only while all outputs are low, and both fall once every gate is closed, including the slow REF output (index 5).
- R5: After power-down is released, the oscillator and VCO enables rise together. No output rises during the following SETTLE_CYC-2 clocks, and all enabled outputs run again afterwards.
- R6: A power-down request during the settle window returns the sequencer to stopping. No output is released, and both enables fall again.
- R7: An output whose enable bit in `out_en_i` is 0 stays low and never toggles, and the other outputs are not affected.
- R8: A change to an enable bit is captured on a rising edge of `pci_clk_i` and applied at the next falling edge of that output's source. For sources at least as fast as the PCI clock, the change is in effect within 2 PCI rising edges.
- R9: `out_oe_o` is 1 (pads driven) when `float_i` is 0, and 0 (all pads high impedance) when `float_i` is 1.
- R10: Every high pulse on an output lasts exactly one half period of its source. Gating never shortens a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n_i | input | 1 | Asynchronous active-low power-down request |
| pci_clk_i | input | 1 | Free-running PCI clock that captures enable changes |
| src_clk_i | input | NOUT | Source clock for each output |
| out_en_i | input | NOUT | Per-output enable, 1 = toggle, 0 = hold low |
| float_i | input | 1 | 1 = put all output pads in high impedance |
| out_o | output | NOUT | Gated output clocks |
| out_oe_o | output | 1 | Pad drive enable, 1 = driven |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
The assertions are checked at every `clk` edge. They cover the stop order (enables fall only with every output low), quiet outputs whenever either enable is low, closed gates throughout each settle window, and the synchroniser depth on wake-up. Pulse integrity, the per-bit independence of the enables, the PCI-edge latency of enable changes and an aborted settle window can only be observed in the bench scenarios. The bench shows these by timing every pulse and counting edges in windows that follow each stimulus.

// File: rtl/clk_gate_seq_pkg.sv
package clk_gate_seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        SEQ_RUN      = 2'd0,
        SEQ_STOPPING = 2'd1,
        SEQ_OFF      = 2'd2,
        SEQ_SETTLING = 2'd3
    } seq_state_e;

    // minimum dwell in STOPPING so that the gate-closed feedback is current
    localparam int MIN_STOP_CYC = 3;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{{WIDTH{RST_VAL}}}};
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/out_gate.sv
module out_gate (
    input  logic src_clk_i,
    input  logic pci_clk_i,
    input  logic rst_n,
    input  logic en_i,
    input  logic allow_i,
    output logic out_o,
    output logic gate_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic en_pci_q;
    logic gate_q;

    // enable changes enter on a free-running PCI rising edge
    always_ff @(posedge pci_clk_i or negedge rst_n) begin
        if (!rst_n) en_pci_q <= 1'b0;
        else        en_pci_q <= en_i;
    end

    // gate updates only while the source is low: no shortened pulses
    always_ff @(negedge src_clk_i or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= en_pci_q & allow_i;
    end

    assign out_o  = src_clk_i & gate_q;
    assign gate_o = gate_q;
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import clk_gate_seq_pkg::*;
#(
    parameter int NOUT       = 7,
    parameter int SETTLE_CYC = 750000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_req_i,
    input  logic [NOUT-1:0] gate_seen_i,
    output logic            allow_o,
    output logic            osc_en_o,
    output logic            vco_en_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(SETTLE_CYC + 1) + 1;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          allow;
        logic          osc_en;
        logic          vco_en;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{
        st: SEQ_SETTLING, cnt: '0, allow: 1'b0, osc_en: 1'b1, vco_en: 1'b1
    };

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_RUN: begin
                if (pd_req_i) begin
                    seq_d.st    = SEQ_STOPPING;
                    seq_d.allow = 1'b0;
                    seq_d.cnt   = '0;
                end
            end
            SEQ_STOPPING: begin
                if (seq_q.cnt < CW'(MIN_STOP_CYC)) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end else if (!(|gate_seen_i)) begin
                    seq_d.st     = SEQ_OFF;
                    seq_d.osc_en = 1'b0;
                    seq_d.vco_en = 1'b0;
                end
            end
            SEQ_OFF: begin
                if (!pd_req_i) begin
                    seq_d.st     = SEQ_SETTLING;
                    seq_d.cnt    = '0;
                    seq_d.osc_en = 1'b1;
                    seq_d.vco_en = 1'b1;
                end
            end
            SEQ_SETTLING: begin
                if (pd_req_i) begin
                    seq_d.st  = SEQ_STOPPING;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    seq_d.st    = SEQ_RUN;
                    seq_d.allow = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign allow_o  = seq_q.allow;
    assign osc_en_o = seq_q.osc_en;
    assign vco_en_o = seq_q.vco_en;
endmodule

// File: rtl/clk_gate_seq.sv
module clk_gate_seq #(
    parameter int NOUT       = 7,
    parameter int SYNC_STG   = 2,
    parameter int SETTLE_CYC = 750000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_n_i,
    input  logic            pci_clk_i,
    input  logic [NOUT-1:0] src_clk_i,
    input  logic [NOUT-1:0] out_en_i,
    input  logic            float_i,
    output logic [NOUT-1:0] out_o,
    output logic            out_oe_o,
    output logic            osc_en_o,
    output logic            vco_en_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic            pd_n_sync;
    logic            allow;
    logic [NOUT-1:0] gate_raw;
    logic [NOUT-1:0] gate_seen;

    sync_chain #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pd_n_i),
        .q_o   (pd_n_sync)
    );

    sync_chain #(.WIDTH(NOUT), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (gate_raw),
        .q_o   (gate_seen)
    );

    pd_sequencer #(.NOUT(NOUT), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req_i    (!pd_n_sync),
        .gate_seen_i (gate_seen),
        .allow_o     (allow),
        .osc_en_o    (osc_en_o),
        .vco_en_o    (vco_en_o)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        out_gate u_gate (
            .src_clk_i (src_clk_i[g]),
            .pci_clk_i (pci_clk_i),
            .rst_n     (rst_n),
            .en_i      (out_en_i[g]),
            .allow_i   (allow),
            .out_o     (out_o[g]),
            .gate_o    (gate_raw[g])
        );
    end

    assign out_oe_o = !float_i;
endmodule

// File: rtl/clk_gate_seq_chk.sv
module clk_gate_seq_chk #(
    parameter int NOUT       = 7,
    parameter int SETTLE_CYC = 750000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pd_n_i,
    input logic [NOUT-1:0] out_o,
    input logic            osc_en_o,
    input logic            vco_en_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(SETTLE_CYC + 1) + 1;

    // cycles since the VCO enable was last seen high after being low
    logic [CW-1:0] wake_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         wake_cnt_q <= '0;
        else if (!vco_en_o)                 wake_cnt_q <= '0;
        else if (wake_cnt_q < CW'(SETTLE_CYC)) wake_cnt_q <= wake_cnt_q + 1'b1;
    end

    assert_vco_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en_o) |-> out_o == '0);

    assert_osc_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> out_o == '0);

    assert_off_outputs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vco_en_o || !osc_en_o) |-> out_o == '0);

    assert_settle_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_en_o && wake_cnt_q < CW'(SETTLE_CYC)) |-> out_o == '0);

    assert_wake_sync_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en_o) |-> $past(pd_n_i, 3));
endmodule

bind clk_gate_seq clk_gate_seq_chk #(.NOUT(NOUT), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_n_i   (pd_n_i),
    .out_o    (out_o),
    .osc_en_o (osc_en_o),
    .vco_en_o (vco_en_o)
);

// File: tb/tb_clk_gate_seq.sv
module tb_clk_gate_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NO     = 7;
    localparam int SETTLE = 40;
    localparam int REF_I  = 5;
    localparam int HP[NO] = '{4, 8, 16, 8, 16, 35, 10};

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic pd_n = 1'b1;
    logic flt = 1'b0;
    logic [NO-1:0] en = '1;
    logic [NO-1:0] out;
    logic out_oe, osc_en, vco_en;

    logic r0 = 1'b0, r1 = 1'b0, r2 = 1'b0, r3 = 1'b0, r4 = 1'b0, r5 = 1'b0, r6 = 1'b0;
    logic [NO-1:0] src;

    always #2  clk = ~clk;
    always #4  r0 = ~r0;
    always #8  r1 = ~r1;
    always #16 r2 = ~r2;
    always #8  r3 = ~r3;
    always #16 r4 = ~r4;
    always #35 r5 = ~r5;
    always #10 r6 = ~r6;

    assign src = {r6 & vco_en, r5 & osc_en, r4 & vco_en, r3 & vco_en,
                  r2 & vco_en, r1 & vco_en, r0 & vco_en};

    clk_gate_seq #(.NOUT(NO), .SETTLE_CYC(SETTLE)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_n_i    (pd_n),
        .pci_clk_i (r4),
        .src_clk_i (src),
        .out_en_i  (en),
        .float_i   (flt),
        .out_o     (out),
        .out_oe_o  (out_oe),
        .osc_en_o  (osc_en),
        .vco_en_o  (vco_en)
    );

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 1'b0;
    int  rises[NO];
    int  runts[NO];
    int  base[NO];
    real rise_t[NO];
    logic [NO-1:0] prev_out = '0;
    logic [NO-1:0] out_at_vco_fall = '1;
    logic [NO-1:0] out_at_osc_fall = '1;

    initial begin
        for (int i = 0; i < NO; i++) begin
            rises[i] = 0; runts[i] = 0; base[i] = 0; rise_t[i] = 0.0;
        end
    end

    // pulse timing monitor (R10)
    always @(out) begin
        for (int i = 0; i < NO; i++) begin
            if (out[i] === 1'b1 && prev_out[i] === 1'b0) begin
                rise_t[i] = $realtime;
                rises[i]++;
            end else if (out[i] === 1'b0 && prev_out[i] === 1'b1) begin
                if ($realtime - rise_t[i] < real'(HP[i]) - 0.01 ||
                    $realtime - rise_t[i] > real'(HP[i]) + 0.01) runts[i]++;
            end
        end
        prev_out = out;
    end

    always @(negedge vco_en) out_at_vco_fall = out;
    always @(negedge osc_en) out_at_osc_fall = out;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic snap();
        for (int i = 0; i < NO; i++) base[i] = rises[i];
    endtask

    task automatic clk_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expect exactly the outputs in mask to have toggled since snap
    task automatic chk_active(input string req, input logic [NO-1:0] mask);
        for (int i = 0; i < NO; i++) begin
            if (mask[i]) chk(req, int'(rises[i] > base[i]), 1);
            else begin
                chk(req, rises[i] - base[i], 0);
                chk(req, int'(out[i]), 0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        clk_edges(10);
        // R1: reset state
        chk("R1 outputs low in reset", int'(out), 0);
        chk("R1 osc on in reset", int'(osc_en), 1);
        chk("R1 vco on in reset", int'(vco_en), 1);
        @(negedge clk);
        rst_n = 1'b1;
        snap();
        clk_edges(SETTLE - 2);
        chk_active("R1 quiet during settle", '0);
        clk_edges(10);
        #160;
        chk_active("R1 running after settle", '1);

        // R9: float control
        flt = 1'b0; #1;
        chk("R9 driven", int'(out_oe), 1);
        flt = 1'b1; #1;
        chk("R9 float", int'(out_oe), 0);
        flt = 1'b0; #1;
        chk("R9 driven again", int'(out_oe), 1);

        // R7: every single-bit-off and single-bit-on pattern
        for (int i = 0; i < NO; i++) begin
            en = ~(NO'(1) << i);
            repeat (3) @(posedge r4);
            #80;
            snap();
            #150;
            chk_active("R7 one output disabled", ~(NO'(1) << i));
        end
        for (int i = 0; i < NO; i++) begin
            en = NO'(1) << i;
            repeat (3) @(posedge r4);
            #80;
            snap();
            #150;
            chk_active("R7 one output enabled", NO'(1) << i);
        end
        en = '1;
        repeat (3) @(posedge r4);
        #80;

        // R8: latency in PCI rising edges for sources no slower than PCI
        for (int i = 0; i < NO; i++) begin
            if (i != REF_I) begin
                @(posedge r4); #2;
                en[i] = 1'b0;
                repeat (2) @(posedge r4);
                #1;
                snap();
                #100;
                chk("R8 disabled within 2 PCI edges", rises[i] - base[i], 0);
                chk("R8 disabled output low", int'(out[i]), 0);
                @(posedge r4); #2;
                en[i] = 1'b1;
                repeat (2) @(posedge r4);
                #1;
                snap();
                #(2 * HP[i] + 1);
                chk("R8 enabled within 2 PCI edges", int'(rises[i] > base[i]), 1);
            end
        end
        #80;

        // R3/R4: power-down
        @(posedge clk); #1;
        pd_n = 1'b0;
        clk_edges(2);
        chk("R4 vco still on before sync", int'(vco_en), 1);
        @(posedge clk); #1;   // third edge: gates close
        #9;
        snap();
        #60;
        chk("R3 cpu stopped", rises[0] - base[0], 0);
        chk("R3 cpu low", int'(out[0]), 0);
        #300;
        chk("R4 all low", int'(out), 0);
        chk("R4 vco off", int'(vco_en), 0);
        chk("R4 osc off", int'(osc_en), 0);
        chk("R4 outputs low at vco fall", int'(out_at_vco_fall), 0);
        chk("R4 outputs low at osc fall", int'(out_at_osc_fall), 0);

        // R2/R5: wake
        @(posedge clk); #1;
        pd_n = 1'b1;
        snap();
        clk_edges(2);
        chk("R2 vco off until synchronised", int'(vco_en), 0);
        clk_edges(1);
        chk("R5 vco back on", int'(vco_en), 1);
        chk("R5 osc back on", int'(osc_en), 1);
        clk_edges(SETTLE - 2);
        chk_active("R5 quiet during settle", '0);
        clk_edges(10);
        #160;
        chk_active("R5 running after settle", '1);

        // R6: request during settle
        pd_n = 1'b0;
        #400;
        chk("R6 off before wake", int'(vco_en), 0);
        pd_n = 1'b1;
        snap();
        clk_edges(3 + SETTLE / 2);
        chk("R6 in settle", int'(vco_en), 1);
        pd_n = 1'b0;
        #400;
        chk_active("R6 never released", '0);
        chk("R6 vco off again", int'(vco_en), 0);
        chk("R6 osc off again", int'(osc_en), 0);
        pd_n = 1'b1;
        clk_edges(SETTLE + 12);
        snap();
        #160;
        chk_active("R6 recovers", '1);

        // R10: no shortened pulses anywhere
        for (int i = 0; i < NO; i++) chk("R10 runt pulses", runts[i], 0);

        finish_run();
    end
endmodule